// File: doc/BRIEF.md
# Two-Lane Floating-Point Status and Exception Controller

This block keeps the status and control word of a two-lane (low and high element) single-precision floating-point unit. At the end of every instruction the datapath sends a result-valid strobe. Alongside it come the two operands of each lane and the lane's own result indications: overflow, underflow, and the guard and sticky bits left over from rounding. For integer or fractional instructions it also sends a low-element overflow bit. The block classifies the operands itself and records invalid-input and divide-by-zero conditions for each lane. It also records the overflow, underflow and inexact indications and keeps a summary integer overflow bit that stays set.

Software reads the register through a read port that is always valid and writes it through a move-to strobe. A written value reaches the register on the next clock and wins over any flag update in the same cycle. The operating-mode field supports only the default mode and always reads 0, so software can find out which mode the hardware supports. One cycle after a floating-point result-valid strobe, the block raises either a data-exception request or a round-exception request, never both. The choice follows the enable bits held in the same register.

Register layout (bit positions): 0 mode (reads 0); 1 summary integer overflow; 2 integer overflow; 3..8 low lane; 9..14 high lane; 15 reserved; 16 invalid enable; 17 divide-by-zero enable; 18 underflow enable; 19 overflow enable; 20 inexact enable; 21..31 reserved. Within a lane's six bits, counting up from the lane base: guard, sticky, invalid, divide-by-zero, underflow, overflow.

Top module: `vfp_status_unit`

## Requirements
- R1: After reset the register reads 0x00000000 and both exception requests are low.
- R2: The mode bit (bit 0) always reads 0, including right after a write of 1 to it.
- R3: Bits 15 and 21..31 always read 0 and ignore writes.
- R4: When regWrEn is high, the register reads regWrData masked to the writable bits (mask 0x001F7FFE) on the next cycle. This holds even when a result-valid strobe arrives in the same cycle.
- R5: On an integer result (resValid=1, isFloat=0), bit 2 takes intOvfLo. Bit 1 is set when intOvfLo=1 and stays set until a software write. Floating-point results leave bits 1 and 2 unchanged.
- R6: On a floating-point result, a lane's invalid bit is set when either of its operands has an all-ones exponent (infinity or NaN) or a zero exponent with a non-zero fraction (denormal). It is also set when isDivide=1 and both operands are ±0.
- R7: On a floating-point result, a lane's divide-by-zero bit is set exactly when isDivide=1, operand B is ±0 and operand A is finite and non-zero.
- R8: On a floating-point result, each lane's overflow and underflow bits take that lane's ovf/unf inputs.
- R9: On a floating-point result, each lane's guard and sticky bits take that lane's inputs. They are forced to 0 when the lane has a data exception, meaning (invalid AND invalid enable) OR (divide-by-zero AND divide-by-zero enable).
- R10: dataExcReq pulses one cycle after a floating-point result-valid strobe when either lane has a data exception. The enables used are the ones held before the strobe.
- R11: roundExcReq pulses one cycle after a floating-point result-valid strobe when the inexact enable is 1, no data exception occurs, and one of these holds: (a) no lane overflows or underflows and some lane has guard or sticky set; (b) some lane overflows and the overflow enable is 0; (c) some lane underflows and the underflow enable is 0.
- R12: The two requests are never high together. Each stays high for one cycle only, and only in the cycle right after a result-valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Software write value |
| regRdData | output | 32 | Current register contents |
| resValid | input | 1 | Instruction result valid |
| isFloat | input | 1 | 1 = floating-point result, 0 = integer/fractional |
| isDivide | input | 1 | Result comes from a divide (A dividend, B divisor) |
| opAHi | input | 32 | High lane operand A |
| opBHi | input | 32 | High lane operand B |
| opALo | input | 32 | Low lane operand A |
| opBLo | input | 32 | Low lane operand B |
| ovfHi | input | 1 | High lane overflow |
| ovfLo | input | 1 | Low lane overflow |
| unfHi | input | 1 | High lane underflow |
| unfLo | input | 1 | Low lane underflow |
| guardHi | input | 1 | High lane guard bit |
| guardLo | input | 1 | Low lane guard bit |
| stickyHi | input | 1 | High lane sticky bit |
| stickyLo | input | 1 | Low lane sticky bit |
| intOvfLo | input | 1 | Low element integer overflow |
| dataExcReq | output | 1 | Data exception request pulse |
| roundExcReq | output | 1 | Round exception request pulse |

## Verification
Every flag is held in a register that the read port shows directly, so a wrong next-state value shows up on regRdData in the cycle right after the strobe that caused it. The request outputs are also registered. A fault in classification, enable selection or priority therefore shows as a missing, extra or doubled pulse in that same cycle. A summary bit that loses its value, or a reserved or mode bit that takes a write, shows on the next read and can stay hidden until software reads the register.

// File: rtl/vfp_status_pkg.sv
package vfp_status_pkg;
  localparam int REG_W    = 32;
  localparam int NLANE    = 2;   // lane 0 = low element, lane 1 = high element
  localparam int LANE_FLD = 6;

  localparam int B_MODE = 0;
  localparam int B_SOV  = 1;
  localparam int B_IOV  = 2;
  localparam int B_LO   = 3;
  localparam int B_EINV = 16;
  localparam int B_EDBZ = 17;
  localparam int B_EUNF = 18;
  localparam int B_EOVF = 19;
  localparam int B_EINX = 20;

  // offsets inside one lane's field group
  localparam int F_G   = 0;
  localparam int F_S   = 1;
  localparam int F_INV = 2;
  localparam int F_DBZ = 3;
  localparam int F_UNF = 4;
  localparam int F_OVF = 5;

  typedef struct packed {
    logic swWr;
    logic fpUpd;
    logic intUpd;
  } strobes_t;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic guard;
    logic sticky;
  } laneRes_t;

  function automatic logic [REG_W-1:0] wrMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = B_SOV; b < B_LO + NLANE*LANE_FLD; b++) m[b] = 1'b1;
    for (int b = B_EINV; b <= B_EINX; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] WR_MASK = wrMask();
endpackage

// File: rtl/vfp_opnd_class.sv
module vfp_opnd_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0] op,
  output logic            isSpecial,
  output logic            isZero,
  output logic            isFiniteNz
);
  logic [EXP_W-1:0]  expF;
  logic [FRAC_W-1:0] fracF;
  logic expMax, expZero, fracZero;

  always_comb begin
    expF       = op[OP_W-2:FRAC_W];
    fracF      = op[FRAC_W-1:0];
    expMax     = &expF;
    expZero    = ~|expF;
    fracZero   = ~|fracF;
    isZero     = expZero & fracZero;
    isSpecial  = expMax | (expZero & ~fracZero);
    isFiniteNz = ~expMax & ~isZero;
  end
endmodule

// File: rtl/vfp_status_dp.sv
module vfp_status_dp
  import vfp_status_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         strb,
  input  logic [REG_W-1:0]                 wrData,
  input  logic                             isDivide,
  input  logic [NLANE-1:0][OP_W-1:0]       opA,
  input  logic [NLANE-1:0][OP_W-1:0]       opB,
  input  laneRes_t [NLANE-1:0]             laneRes,
  input  logic                             intOvfLo,
  output logic [REG_W-1:0]                 regQ,
  output logic [NLANE-1:0]                 laneDx,
  output logic                             anyOvf,
  output logic                             anyUnf,
  output logic                             anyInex
);
  logic [NLANE-1:0] laneInv, laneDbz;
  logic [REG_W-1:0] regD;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic aSp, aZ, aFnz, bSp, bZ, bFnz;
    vfp_opnd_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_clsA (
      .op(opA[l]), .isSpecial(aSp), .isZero(aZ), .isFiniteNz(aFnz));
    vfp_opnd_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_clsB (
      .op(opB[l]), .isSpecial(bSp), .isZero(bZ), .isFiniteNz(bFnz));
    assign laneInv[l] = aSp | bSp | (isDivide & aZ & bZ);
    assign laneDbz[l] = isDivide & bZ & aFnz;
    assign laneDx[l]  = (laneInv[l] & regQ[B_EINV]) | (laneDbz[l] & regQ[B_EDBZ]);
  end

  always_comb begin
    anyOvf  = 1'b0;
    anyUnf  = 1'b0;
    anyInex = 1'b0;
    for (int l = 0; l < NLANE; l++) begin
      anyOvf  = anyOvf  | laneRes[l].ovf;
      anyUnf  = anyUnf  | laneRes[l].unf;
      anyInex = anyInex | laneRes[l].guard | laneRes[l].sticky;
    end
  end

  always_comb begin
    regD = regQ;
    if (strb.swWr) begin
      regD = wrData & WR_MASK;
    end else begin
      if (strb.fpUpd) begin
        for (int l = 0; l < NLANE; l++) begin
          regD[B_LO + l*LANE_FLD + F_G]   = laneDx[l] ? 1'b0 : laneRes[l].guard;
          regD[B_LO + l*LANE_FLD + F_S]   = laneDx[l] ? 1'b0 : laneRes[l].sticky;
          regD[B_LO + l*LANE_FLD + F_INV] = laneInv[l];
          regD[B_LO + l*LANE_FLD + F_DBZ] = laneDbz[l];
          regD[B_LO + l*LANE_FLD + F_UNF] = laneRes[l].unf;
          regD[B_LO + l*LANE_FLD + F_OVF] = laneRes[l].ovf;
        end
      end
      if (strb.intUpd) begin
        regD[B_IOV] = intOvfLo;
        regD[B_SOV] = regQ[B_SOV] | intOvfLo;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regD;
  end
endmodule

// File: rtl/vfp_status_ctl.sv
module vfp_status_ctl
  import vfp_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             resValid,
  input  logic             isFloat,
  input  logic [NLANE-1:0] laneDx,
  input  logic             anyOvf,
  input  logic             anyUnf,
  input  logic             anyInex,
  input  logic             enOvf,
  input  logic             enUnf,
  input  logic             enInx,
  output strobes_t         strb,
  output logic             dataExcReq,
  output logic             roundExcReq
);
  logic dxNow, rxNow, rxCause;

  always_comb begin
    strb.swWr   = regWrEn;
    strb.fpUpd  = resValid & isFloat;
    strb.intUpd = resValid & ~isFloat;
    dxNow   = strb.fpUpd & (|laneDx);
    rxCause = (~anyOvf & ~anyUnf & anyInex) | (anyOvf & ~enOvf) | (anyUnf & ~enUnf);
    rxNow   = strb.fpUpd & ~dxNow & enInx & rxCause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataExcReq  <= 1'b0;
      roundExcReq <= 1'b0;
    end else begin
      dataExcReq  <= dxNow;
      roundExcReq <= rxNow;
    end
  end
endmodule

// File: rtl/vfp_status_unit.sv
module vfp_status_unit
  import vfp_status_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             resValid,
  input  logic             isFloat,
  input  logic             isDivide,
  input  logic [OP_W-1:0]  opAHi,
  input  logic [OP_W-1:0]  opBHi,
  input  logic [OP_W-1:0]  opALo,
  input  logic [OP_W-1:0]  opBLo,
  input  logic             ovfHi,
  input  logic             ovfLo,
  input  logic             unfHi,
  input  logic             unfLo,
  input  logic             guardHi,
  input  logic             guardLo,
  input  logic             stickyHi,
  input  logic             stickyLo,
  input  logic             intOvfLo,
  output logic             dataExcReq,
  output logic             roundExcReq
);
  strobes_t                   strb;
  logic [NLANE-1:0][OP_W-1:0] opA, opB;
  laneRes_t [NLANE-1:0]       laneRes;
  logic [NLANE-1:0]           laneDx;
  logic                       anyOvf, anyUnf, anyInex;
  logic [REG_W-1:0]           regQ;

  assign opA[0] = opALo;
  assign opA[1] = opAHi;
  assign opB[0] = opBLo;
  assign opB[1] = opBHi;
  assign laneRes[0] = '{ovf: ovfLo, unf: unfLo, guard: guardLo, sticky: stickyLo};
  assign laneRes[1] = '{ovf: ovfHi, unf: unfHi, guard: guardHi, sticky: stickyHi};
  assign regRdData = regQ;

  vfp_status_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .resValid(resValid), .isFloat(isFloat),
    .laneDx(laneDx), .anyOvf(anyOvf), .anyUnf(anyUnf), .anyInex(anyInex),
    .enOvf(regQ[B_EOVF]), .enUnf(regQ[B_EUNF]), .enInx(regQ[B_EINX]),
    .strb(strb), .dataExcReq(dataExcReq), .roundExcReq(roundExcReq));

  vfp_status_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .isDivide(isDivide),
    .opA(opA), .opB(opB), .laneRes(laneRes), .intOvfLo(intOvfLo),
    .regQ(regQ), .laneDx(laneDx), .anyOvf(anyOvf), .anyUnf(anyUnf), .anyInex(anyInex));
endmodule

// File: rtl/vfp_status_chk.sv
module vfp_status_chk
  import vfp_status_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             resValid,
  input logic             dataExcReq,
  input logic             roundExcReq
);
  // R2
  a_r2_mode_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[B_MODE] == 1'b0);
  // R3
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~WR_MASK) == '0);
  // R4
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == ($past(regWrData) & WR_MASK));
  // R5
  a_r5_summary_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && regRdData[B_SOV]) |=> regRdData[B_SOV]);
  // R12
  a_r12_single_request: assert property (@(posedge clk) disable iff (!rstN)
    !(dataExcReq && roundExcReq));
  a_r12_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    (dataExcReq || roundExcReq) |-> $past(resValid));
endmodule

bind vfp_status_unit vfp_status_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .resValid(resValid),
  .dataExcReq(dataExcReq), .roundExcReq(roundExcReq));

// File: tb/tb_vfp_status_unit.sv
module tb_vfp_status_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic resValid = 1'b0, isFloat = 1'b0, isDivide = 1'b0;
  logic [31:0] opAHi = '0, opBHi = '0, opALo = '0, opBLo = '0;
  logic ovfHi = 0, ovfLo = 0, unfHi = 0, unfLo = 0;
  logic guardHi = 0, guardLo = 0, stickyHi = 0, stickyLo = 0, intOvfLo = 0;
  logic dataExcReq, roundExcReq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vfp_status_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // class 0:+0 1:-0 2:normal 3:denormal 4:infinity 5:NaN
  function automatic logic [31:0] clsVal(input int c);
    case (c)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h3F80_0000;
      3: return 32'h0000_0001;
      4: return 32'h7F80_0000;
      default: return 32'h7FC0_0000;
    endcase
  endfunction

  task automatic swWrite(input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset reg", regRdData, 32'h0);
    chk("R1 reset req", {30'd0, dataExcReq, roundExcReq}, 32'h0);

    swWrite(32'hFFFF_FFFF);
    chk("R2 R3 R4 all-ones write", regRdData, 32'h001F_7FFE);
    chk("R2 mode bit", {31'd0, regRdData[0]}, 32'h0);
    chk("R3 reserved bits", regRdData & 32'hFFE0_8001, 32'h0);
    swWrite(32'h0000_0001);
    chk("R2 mode write of 1", regRdData, 32'h0);

    // R5 integer overflow and summary
    @(negedge clk); resValid = 1; isFloat = 0; intOvfLo = 1;
    @(negedge clk); resValid = 0; intOvfLo = 0;
    chk("R5 int overflow set", regRdData, 32'h6);
    @(negedge clk); resValid = 1; isFloat = 0; intOvfLo = 0;
    @(negedge clk); resValid = 0;
    chk("R5 summary stays", regRdData, 32'h2);
    @(negedge clk); resValid = 1; isFloat = 1; isDivide = 0;
    opALo = clsVal(2); opBLo = clsVal(2); opAHi = clsVal(2); opBHi = clsVal(2);
    @(negedge clk); resValid = 0;
    chk("R5 fp leaves int bits", regRdData, 32'h2);
    swWrite(32'h0);
    chk("R5 summary cleared by write", regRdData, 32'h0);

    // R4 write wins over same-cycle update
    @(negedge clk); regWrEn = 1; regWrData = 32'h0001_0000;
    resValid = 1; isFloat = 1; opALo = clsVal(4);
    @(negedge clk); regWrEn = 0; resValid = 0;
    chk("R4 write beats update", regRdData, 32'h0001_0000);
    @(negedge clk);

    // sweep of operand classes, divide flag, enables and lane indications
    for (int n = 0; n < 2592; n++) begin
      int aL, bL, aH, bH, dv, en, fl;
      logic [1:0] inv, dbz, dx, ov, un, g, s;
      logic [31:0] exp;
      logic expDx, expRx;
      int a[2], b[2];
      aL = n % 6; bL = (n / 6) % 6; aH = (n / 36) % 6; bH = (n / 216) % 6;
      dv = (n / 1296) % 2;
      en = (n * 7 + 3) % 32;
      fl = (n * 13 + 5) % 256;
      a[0] = aL; b[0] = bL; a[1] = aH; b[1] = bH;
      ov = {fl[1], fl[0]}; un = {fl[3], fl[2]};
      g  = {fl[5], fl[4]}; s  = {fl[7], fl[6]};
      exp = 32'(en) << 16;
      for (int l = 0; l < 2; l++) begin
        inv[l] = (a[l] >= 3) || (b[l] >= 3) || (dv == 1 && a[l] < 2 && b[l] < 2);
        dbz[l] = (dv == 1) && (b[l] < 2) && (a[l] == 2 || a[l] == 3);
        dx[l]  = (inv[l] && en[0]) || (dbz[l] && en[1]);
        exp[3 + l*6 + 0] = dx[l] ? 1'b0 : g[l];
        exp[3 + l*6 + 1] = dx[l] ? 1'b0 : s[l];
        exp[3 + l*6 + 2] = inv[l];
        exp[3 + l*6 + 3] = dbz[l];
        exp[3 + l*6 + 4] = un[l];
        exp[3 + l*6 + 5] = ov[l];
      end
      expDx = |dx;
      expRx = en[4] && !expDx &&
              ((!(|ov) && !(|un) && (|(g | s))) || ((|ov) && !en[3]) || ((|un) && !en[2]));

      swWrite(32'(en) << 16);
      resValid = 1; isFloat = 1; isDivide = dv[0];
      opALo = clsVal(aL); opBLo = clsVal(bL); opAHi = clsVal(aH); opBHi = clsVal(bH);
      ovfLo = ov[0]; ovfHi = ov[1]; unfLo = un[0]; unfHi = un[1];
      guardLo = g[0]; guardHi = g[1]; stickyLo = s[0]; stickyHi = s[1];
      @(negedge clk);
      resValid = 0;
      chk("R6 R7 R8 R9 flags", regRdData, exp);
      chk("R10 data request", {31'd0, dataExcReq}, {31'd0, expDx});
      chk("R11 round request", {31'd0, roundExcReq}, {31'd0, expRx});
      @(negedge clk);
      chk("R12 single-cycle pulse", {30'd0, dataExcReq, roundExcReq}, 32'h0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule